// File: doc/BRIEF.md
# Scalar Double-Precision Minimum Unit

This block picks the smaller of two binary64 floating-point values and writes it into the low lane of a wide destination vector. The selection rules are deliberately lopsided. The second operand is returned whenever either value is a NaN, and also when both values are zeros of any sign. It is returned as well when the two values are equal. The first operand wins only when it is an ordered value strictly below the second. A signalling NaN in the second operand passes through bit for bit, with no quieting.

The lanes above the low one are built in one of two ways, chosen per operation. In three-operand mode, the second lane comes from the first source vector and every higher lane is cleared. In two-operand (legacy) mode, the first operand is taken from the destination's own previous low lane, and all upper lanes keep their previous contents. Alongside the result, two flags report whether a compared value was a NaN (invalid) and whether a compared value was subnormal (denormal). The result and the flags are registered, and they appear one cycle after an input strobe together with an output valid.

Top module: `dmin_unit`

## Requirements
- R1: For two ordered values that are not both zero, result_o[63:0] equals the first operand only when the first operand is strictly less than src2_i. Otherwise, equal values included, it equals src2_i.
- R2: When both compared values are zero (bits [62:0] all clear), result_o[63:0] equals src2_i bit-exact, whatever the two sign bits are.
- R3: A value is a NaN when bits [62:52] are all ones and bits [51:0] are nonzero. When either compared value is a NaN, result_o[63:0] equals src2_i bit-exact, and a signalling NaN (bit 51 clear) is not quieted.
- R4: The ordering follows the sign and the magnitude. A negative value is below a positive value. Among negatives, the larger magnitude is smaller. Subnormals compare by their value, with no flushing. Infinities (bits [62:52] all ones, fraction zero) order as ordinary values.
- R5: With mode_i=1, the first operand is src1_i[63:0], result_o[127:64] equals src1_i[127:64], and result_o[255:128] is zero.
- R6: With mode_i=0, the first operand is dst_prev_i[63:0], result_o[255:64] equals dst_prev_i[255:64], and src1_i has no effect on the result.
- R7: invalid_o is 1 exactly when at least one of the two compared values is a NaN, quiet or signalling.
- R8: denormal_o is 1 exactly when at least one compared value has bits [62:52] zero and bits [51:0] nonzero.
- R9: out_valid_o is in_valid_i delayed by one clock. result_o, invalid_o and denormal_o update only on a cycle that has in_valid_i high and hold otherwise. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands are valid this cycle |
| mode_i | input | 1 | 1: three-operand merge, 0: legacy merge |
| src1_i | input | 128 | First source vector |
| src2_i | input | 64 | Second source value |
| dst_prev_i | input | 256 | Previous destination contents |
| out_valid_o | output | 1 | Result registered from the prior strobe |
| result_o | output | 256 | Destination vector |
| invalid_o | output | 1 | A compared value was a NaN |
| denormal_o | output | 1 | A compared value was subnormal |

## Verification
The bench builds the block with its default parameters: 11 exponent bits, 52 fraction bits, two source lanes and four destination lanes. With this true binary64 layout, the bench's reference can order values through the simulator's own real arithmetic, independently of the RTL. With four destination lanes, both the copied second lane and the cleared or kept lanes above it are visible. Directed vectors cover signed-zero pairs, signalling and quiet NaNs in each position, infinities and subnormals. Random vectors with biased exponents run in both merge modes.

// File: rtl/dmin_pkg.sv
package dmin_pkg;

   typedef enum logic {
      MERGE_KEEP    = 1'b0,
      MERGE_ZERO_HI = 1'b1
   } merge_mode_t;

   typedef struct packed {
      logic sign;
      logic is_nan;
      logic is_zero;
      logic is_denorm;
   } fp_class_t;

endpackage

// File: rtl/dmin_classify.sv
module dmin_classify
   import dmin_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] val_i,
   output fp_class_t    cls_o,
   output logic [W-2:0] mag_o
);
   logic [EXP_W-1:0]  expo;
   logic [FRAC_W-1:0] frac;
   logic              exp_ones, exp_zero, frac_zero;

   assign expo      = val_i[W-2 -: EXP_W];
   assign frac      = val_i[FRAC_W-1:0];
   assign exp_ones  = &expo;
   assign exp_zero  = ~|expo;
   assign frac_zero = ~|frac;

   always_comb begin
      cls_o.sign      = val_i[W-1];
      cls_o.is_nan    = exp_ones & ~frac_zero;
      cls_o.is_zero   = exp_zero & frac_zero;
      cls_o.is_denorm = exp_zero & ~frac_zero;
   end

   assign mag_o = val_i[W-2:0];
endmodule

// File: rtl/dmin_select.sv
module dmin_select
   import dmin_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  fp_class_t    cls_a_i,
   input  fp_class_t    cls_b_i,
   input  logic [W-2:0] mag_a_i,
   input  logic [W-2:0] mag_b_i,
   output logic [W-1:0] min_o
);
   logic ordered_lt, take_a;

   always_comb begin
      if (cls_a_i.sign != cls_b_i.sign)
         ordered_lt = cls_a_i.sign;
      else if (cls_a_i.sign)
         ordered_lt = mag_a_i > mag_b_i;
      else
         ordered_lt = mag_a_i < mag_b_i;
   end

   assign take_a = ordered_lt & ~cls_a_i.is_nan & ~cls_b_i.is_nan
                 & ~(cls_a_i.is_zero & cls_b_i.is_zero);
   assign min_o  = take_a ? a_i : b_i;
endmodule

// File: rtl/dmin_merge.sv
module dmin_merge #(
   parameter int LANE_W    = 64,
   parameter int SRC_LANES = 2,
   parameter int DST_LANES = 4
) (
   input  logic                        mode_i,
   input  logic [SRC_LANES*LANE_W-1:0] src1_i,
   input  logic [DST_LANES*LANE_W-1:0] prev_i,
   input  logic [LANE_W-1:0]           low_i,
   output logic [DST_LANES*LANE_W-1:0] res_o
);
   assign res_o[LANE_W-1:0] = low_i;

   for (genvar g = 1; g < DST_LANES; g++) begin : g_lane
      if (g < SRC_LANES) begin : g_copy
         assign res_o[g*LANE_W +: LANE_W] =
            mode_i ? src1_i[g*LANE_W +: LANE_W] : prev_i[g*LANE_W +: LANE_W];
      end else begin : g_clear
         assign res_o[g*LANE_W +: LANE_W] =
            mode_i ? '0 : prev_i[g*LANE_W +: LANE_W];
      end
   end
endmodule

// File: rtl/dmin_unit.sv
module dmin_unit
   import dmin_pkg::*;
#(
   parameter int EXP_W     = 11,
   parameter int FRAC_W    = 52,
   parameter int SRC_LANES = 2,
   parameter int DST_LANES = 4,
   localparam int LANE_W   = 1 + EXP_W + FRAC_W,
   localparam int SRC_W    = SRC_LANES * LANE_W,
   localparam int DST_W    = DST_LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   input  logic              mode_i,
   input  logic [SRC_W-1:0]  src1_i,
   input  logic [LANE_W-1:0] src2_i,
   input  logic [DST_W-1:0]  dst_prev_i,
   output logic              out_valid_o,
   output logic [DST_W-1:0]  result_o,
   output logic              invalid_o,
   output logic              denormal_o
);
   if (EXP_W < 2 || FRAC_W < 1) begin : g_bad_fmt
      $error("dmin_unit: exponent or fraction field too narrow");
   end
   if (SRC_LANES < 1 || DST_LANES < SRC_LANES) begin : g_bad_lanes
      $error("dmin_unit: lane counts must satisfy 1 <= SRC_LANES <= DST_LANES");
   end

   merge_mode_t        mode;
   logic [LANE_W-1:0]  opnd [2];
   fp_class_t          cls  [2];
   logic [LANE_W-2:0]  mag  [2];
   logic [LANE_W-1:0]  low_min;
   logic [DST_W-1:0]   merged;

   assign mode    = merge_mode_t'(mode_i);
   assign opnd[0] = (mode == MERGE_ZERO_HI) ? src1_i[LANE_W-1:0] : dst_prev_i[LANE_W-1:0];
   assign opnd[1] = src2_i;

   for (genvar k = 0; k < 2; k++) begin : g_cls
      dmin_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .val_i (opnd[k]),
         .cls_o (cls[k]),
         .mag_o (mag[k])
      );
   end

   dmin_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
      .a_i     (opnd[0]),
      .b_i     (opnd[1]),
      .cls_a_i (cls[0]),
      .cls_b_i (cls[1]),
      .mag_a_i (mag[0]),
      .mag_b_i (mag[1]),
      .min_o   (low_min)
   );

   dmin_merge #(.LANE_W(LANE_W), .SRC_LANES(SRC_LANES), .DST_LANES(DST_LANES)) u_mrg (
      .mode_i (mode_i),
      .src1_i (src1_i),
      .prev_i (dst_prev_i),
      .low_i  (low_min),
      .res_o  (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         result_o    <= '0;
         invalid_o   <= 1'b0;
         denormal_o  <= 1'b0;
      end else begin
         out_valid_o <= in_valid_i;
         if (in_valid_i) begin
            result_o   <= merged;
            invalid_o  <= cls[0].is_nan | cls[1].is_nan;
            denormal_o <= cls[0].is_denorm | cls[1].is_denorm;
         end
      end
   end
endmodule

// File: rtl/dmin_unit_chk.sv
module dmin_unit_chk #(
   parameter int EXP_W     = 11,
   parameter int FRAC_W    = 52,
   parameter int SRC_LANES = 2,
   parameter int DST_LANES = 4,
   localparam int LANE_W   = 1 + EXP_W + FRAC_W,
   localparam int SRC_W    = SRC_LANES * LANE_W,
   localparam int DST_W    = DST_LANES * LANE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid_i,
   input logic              mode_i,
   input logic [SRC_W-1:0]  src1_i,
   input logic [LANE_W-1:0] src2_i,
   input logic [DST_W-1:0]  dst_prev_i,
   input logic              out_valid_o,
   input logic [DST_W-1:0]  result_o,
   input logic              invalid_o,
   input logic              denormal_o
);
   logic              b_nan;
   logic [LANE_W-1:0] first_op;

   assign b_nan    = (&src2_i[LANE_W-2 -: EXP_W]) & (|src2_i[FRAC_W-1:0]);
   assign first_op = mode_i ? src1_i[LANE_W-1:0] : dst_prev_i[LANE_W-1:0];

   // R9
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_valid_o == $past(in_valid_i));

   // R9
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid_i |=> $stable(result_o) && $stable(invalid_o) && $stable(denormal_o));

   // R1
   pick_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i |=> (result_o[LANE_W-1:0] == $past(src2_i)) ||
                     (result_o[LANE_W-1:0] == $past(first_op)));

   // R3
   nan_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i && b_nan |=> result_o[LANE_W-1:0] == $past(src2_i) && invalid_o);

   // R5
   zero_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i && mode_i |=> result_o[DST_W-1:SRC_W] == '0 &&
         result_o[SRC_W-1:LANE_W] == $past(src1_i[SRC_W-1:LANE_W]));

   // R6
   keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i && !mode_i |=> result_o[DST_W-1:LANE_W] == $past(dst_prev_i[DST_W-1:LANE_W]));
endmodule

bind dmin_unit dmin_unit_chk #(
   .EXP_W(EXP_W), .FRAC_W(FRAC_W), .SRC_LANES(SRC_LANES), .DST_LANES(DST_LANES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .mode_i(mode_i),
   .src1_i(src1_i), .src2_i(src2_i), .dst_prev_i(dst_prev_i),
   .out_valid_o(out_valid_o), .result_o(result_o),
   .invalid_o(invalid_o), .denormal_o(denormal_o)
);

// File: tb/dmin_unit_test.sv
`timescale 1ns/1ps
module dmin_unit_test;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid_i;
   logic         mode_i;
   logic [127:0] src1_i;
   logic [63:0]  src2_i;
   logic [255:0] dst_prev_i;
   logic         out_valid_o;
   logic [255:0] result_o;
   logic         invalid_o;
   logic         denormal_o;

   always #2.5 clk = ~clk;

   dmin_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .mode_i(mode_i),
      .src1_i(src1_i), .src2_i(src2_i), .dst_prev_i(dst_prev_i),
      .out_valid_o(out_valid_o), .result_o(result_o),
      .invalid_o(invalid_o), .denormal_o(denormal_o)
   );

   typedef struct {
      logic [255:0] res;
      logic         inv;
      logic         den;
      logic         mode;
      string        req;
   } exp_t;

   exp_t sbq[$];
   int   nvec  = 0;
   int   nfail = 0;
   bit   done  = 1'b0;

   localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
   localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
   localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
   localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
   localparam logic [63:0] NSNAN = 64'hFFF4_0000_0000_00A5;
   localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
   localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
   localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] MTWO  = 64'hC000_0000_0000_0000;
   localparam logic [63:0] DEN1  = 64'h0000_0000_0000_0001;
   localparam logic [63:0] DEN2  = 64'h000F_FFFF_FFFF_FFFF;
   localparam logic [63:0] NDEN  = 64'h8000_0000_0000_0003;

   function automatic bit f_nan(logic [63:0] v);
      return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
   endfunction
   function automatic bit f_den(logic [63:0] v);
      return (v[62:52] == 11'h000) && (v[51:0] != 0);
   endfunction
   function automatic bit f_inf(logic [63:0] v);
      return (v[62:52] == 11'h7FF) && (v[51:0] == 0);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic m, input logic [127:0] s1, input logic [63:0] s2, input logic [255:0] dp);
      exp_t        e;
      logic [63:0] a;
      logic [63:0] lo;
      a = m ? s1[63:0] : dp[63:0];
      if (f_nan(a) || f_nan(s2)) begin
         lo = s2; e.req = "R3";
      end else if (a[62:0] == 0 && s2[62:0] == 0) begin
         lo = s2; e.req = "R2";
      end else begin
         lo = ($bitstoreal(a) < $bitstoreal(s2)) ? a : s2;
         e.req = (a[63] != s2[63] || f_den(a) || f_den(s2) || f_inf(a) || f_inf(s2)) ? "R4" : "R1";
      end
      e.res  = m ? {128'b0, s1[127:64], lo} : {dp[255:64], lo};
      e.inv  = f_nan(a) || f_nan(s2);
      e.den  = f_den(a) || f_den(s2);
      e.mode = m;
      @(negedge clk);
      mode_i     = m;
      src1_i     = s1;
      src2_i     = s2;
      dst_prev_i = dp;
      in_valid_i = 1'b1;
      sbq.push_back(e);
      nvec++;
   endtask

   function automatic logic [63:0] rnd_dbl();
      logic [63:0] r;
      r = {$urandom, $urandom};
      case ($urandom % 8)
         0: r[62:52] = 11'h000;
         1: r[62:52] = 11'h7FF;
         2: r[51:0]  = ($urandom % 2) ? 52'h0 : r[51:0];
         default: ;
      endcase
      return r;
   endfunction

   always @(negedge clk) begin
      if (rst_n && out_valid_o) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R9 unexpected valid", result_o, 256'h0);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            chk(result_o[63:0] == e.res[63:0], e.req, {192'h0, result_o[63:0]}, {192'h0, e.res[63:0]});
            chk(result_o[255:64] == e.res[255:64], e.mode ? "R5" : "R6", result_o, e.res);
            chk(invalid_o == e.inv, "R7", {255'h0, invalid_o}, {255'h0, e.inv});
            chk(denormal_o == e.den, "R8", {255'h0, denormal_o}, {255'h0, e.den});
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         nfail++;
         $display("FAIL R9 watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      logic [255:0] held;
      rst_n      = 1'b0;
      in_valid_i = 1'b0;
      mode_i     = 1'b0;
      src1_i     = '0;
      src2_i     = '0;
      dst_prev_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(out_valid_o == 1'b0 && invalid_o == 1'b0 && denormal_o == 1'b0, "R9 reset flags",
          {253'h0, out_valid_o, invalid_o, denormal_o}, 256'h0);
      chk(result_o == 256'h0, "R9 reset result", result_o, 256'h0);

      // R2 signed zero pairs, both modes
      drive(1, {64'hAAAA_0000_1111_2222, NZERO}, PZERO, {256{1'b1}});
      drive(1, {64'h1234, PZERO}, NZERO, '0);
      drive(0, {128{1'b1}}, NZERO, {192'h5555, NZERO});
      drive(0, '0, PZERO, {192'hABC, PZERO});
      // R3 NaNs in each position, signalling kept exact
      drive(1, {64'h9, SNAN}, ONE, '0);
      drive(1, {64'h9, ONE}, SNAN, '0);
      drive(1, {64'h9, QNAN}, MTWO, '0);
      drive(1, {64'h9, MTWO}, QNAN, '0);
      drive(0, '0, NSNAN, {192'h77, SNAN});
      drive(1, {64'h0, NINF}, NSNAN, '0);
      // R4 infinities and subnormals
      drive(1, {64'h1, NINF}, MTWO, '0);
      drive(1, {64'h1, PINF}, ONE, '0);
      drive(1, {64'h1, DEN1}, DEN2, '0);
      drive(1, {64'h1, DEN2}, PZERO, '0);
      drive(1, {64'h1, NDEN}, PZERO, '0);
      drive(0, {128{1'b1}}, NDEN, {192'hFEED, DEN1});
      // R1 equal values and plain ordering
      drive(1, {64'h2, ONE}, ONE, '0);
      drive(1, {64'h2, ONE}, 64'h4000_0000_0000_0000, '0);
      drive(0, '0, ONE, {192'h3, 64'h3FE0_0000_0000_0000});

      // R6 src1 ignored in legacy mode: same prev, two different src1 values
      drive(0, {128{1'b1}}, ONE, {192'h42, MTWO});
      drive(0, '0,          ONE, {192'h42, MTWO});

      for (int i = 0; i < 600; i++) begin
         logic [63:0] a, b;
         a = rnd_dbl();
         b = ($urandom % 10 == 0) ? (a ^ {($urandom % 2 == 1), 63'h0}) : rnd_dbl();
         drive(i % 2, {$urandom, $urandom, $urandom, $urandom} & {64'hFFFF_FFFF_FFFF_FFFF, 64'h0} | {64'h0, a},
               b, {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, 64'h0} | {192'h0, a});
      end

      @(negedge clk);
      in_valid_i = 1'b0;
      @(negedge clk);
      held = result_o;
      // R9 idle inputs have no effect
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         src1_i     = {$urandom, $urandom, $urandom, $urandom};
         src2_i     = QNAN;
         dst_prev_i = {8{$urandom}};
         mode_i     = ~mode_i;
      end
      @(negedge clk);
      chk(result_o == held, "R9 hold", result_o, held);
      chk(out_valid_o == 1'b0, "R9 idle valid", {255'h0, out_valid_o}, 256'h0);
      chk(sbq.size() == 0, "R9 all results seen", 256'(sbq.size()), 256'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule